// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits on the CPU side of a bridge and decides, one access at a time, whether an address belongs to the downstream bus. The upper 256 MiB of the 32-bit space is split into 32 slices of 8 MiB. Of these, the slices numbered 1 to 30 can be switched on one by one and forwarded. Slice 0 always belongs to boot firmware and slice 31 always belongs to the bridge's own registers, so neither is ever forwarded.

Two registers set the behaviour. A control register holds a two-bit global forwarding code. A 32-bit slice-enable register holds one bit per slice. Each request gives an address and a valid strobe. One cycle later the block returns a registered result: a valid flag, a forward flag, the 5-bit slice number, and the address passed through unchanged. The address is not translated.

Top module: `owd_top`

## Requirements
- R1: Forwarding is globally on only when control bits [8:7] equal binary 01. The codes 00, 10 and 11 disable every slice, and the other control bits have no effect.
- R2: The slice number is request address bits [27:23], and it applies only when address bits [31:28] equal 0xF. An address outside that region never forwards.
- R3: Enable bits 0 and 31 are ignored, so addresses in slice 0 or slice 31 never forward.
- R4: A valid request to slice i (1 to 30) forwards when forwarding is globally on and enable bit i is set. This holds from the first byte of the slice to its last byte.
- R5: Each result appears on the outputs exactly one cycle after its request. `fwd_valid` repeats `req_valid`. `fwd_addr` holds the address of the most recent valid request, unchanged.
- R6: A register write (`cfg_sel` 0 = control, 1 = slice enable) takes effect for requests presented in any later cycle. A request in the same cycle as the write is decoded with the old value.
- R7: Reset (synchronous, active high) clears both registers and all outputs, so nothing forwards until software configures the block.
- R8: `fwd_index` is 0 whenever `fwd_hit` is low, and `fwd_hit` is never high without `fwd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 slice enable |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| fwd_valid | output | 1 | Registered copy of the request strobe |
| fwd_hit | output | 1 | Request is forwarded downstream |
| fwd_index | output | 5 | Slice number of a forwarded request, else 0 |
| fwd_addr | output | 32 | Address of the latest valid request |

## Verification
The hardest case to reach is a register write and a request in the same cycle, because the decode must use the value that is being replaced. The stimulus issues a slice-enable write and a request to a just-enabled slice in one cycle. It then repeats the request in the next cycle, so the old-value and new-value outcomes are both seen back to back. The same is done for the control code. Slice boundaries are reached by sending the first and last byte of every slice while all enables are set, so the edge slices 0 and 31 are probed with their enable bits set.

// File: rtl/owd_pkg.sv
package owd_pkg;
  // register select encoding on the configuration port
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_WEN  = 1'b1;

  // decode result carried from the match logic to the output stage
  typedef struct packed {
    logic       hit;
    logic [4:0] idx;
  } owd_result_t;
endpackage

// File: rtl/owd_cfg_regs.sv
module owd_cfg_regs #(
  parameter int DATA_W     = 32,
  parameter int NUM_WIN    = 32,
  parameter int GEN_LSB    = 7,
  parameter int GEN_W      = 2,
  parameter logic [1:0] GEN_CODE = 2'b01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic               glob_en,
  output logic [NUM_WIN-1:0] win_en
);
  import owd_pkg::*;

  localparam int LAST_WIN = NUM_WIN - 1;

  logic [GEN_W-1:0] gen_q;

  always_ff @(posedge clk) begin
    if (rst)
      gen_q <= '0;
    else if (we && sel == SEL_CTRL)
      gen_q <= wdata[GEN_LSB +: GEN_W];
  end

  assign glob_en = (gen_q == GEN_W'(GEN_CODE));

  // one flop per usable slice; edge slices are tied off
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    if (i == 0 || i == LAST_WIN) begin : g_fixed
      assign win_en[i] = 1'b0;
    end else begin : g_flop
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)
          bit_q <= 1'b0;
        else if (we && sel == SEL_WEN)
          bit_q <= wdata[i];
      end
      assign win_en[i] = bit_q;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[0], wdata[LAST_WIN]};

  // R3: edge slices can never be enabled, whatever was written
  p_edge_off_r3: assert property (@(posedge clk) disable iff (rst)
    !win_en[0] && !win_en[LAST_WIN]);

  // R6: a write to the enable register shows up on the next cycle
  p_wen_update_r6: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_WEN) |=> win_en[LAST_WIN-1:1] == $past(wdata[LAST_WIN-1:1]));
endmodule

// File: rtl/owd_window_match.sv
module owd_window_match #(
  parameter int ADDR_W   = 32,
  parameter int WIN_LSB  = 23,
  parameter int WIN_BITS = 5,
  parameter logic [3:0] REGION_TAG = 4'hF
) (
  input  logic                     glob_en,
  input  logic [(1<<WIN_BITS)-1:0] win_en,
  input  logic [ADDR_W-1:0]        addr,
  output owd_pkg::owd_result_t     res
);
  localparam int NUM_WIN = 1 << WIN_BITS;
  localparam int TAG_LSB = WIN_LSB + WIN_BITS;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  logic               in_region;
  logic [WIN_BITS-1:0] slice;
  logic [NUM_WIN-1:0] match;

  assign in_region = (addr[ADDR_W-1:TAG_LSB] == TAG_W'(REGION_TAG));
  assign slice     = addr[WIN_LSB +: WIN_BITS];

  // one comparator per slice, qualified by that slice's enable
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    assign match[i] = in_region && (slice == WIN_BITS'(i)) && win_en[i];
  end

  always_comb begin
    res.hit = glob_en && (|match);
    res.idx = res.hit ? 5'(slice) : 5'd0;
  end

  logic unused_low;
  assign unused_low = ^addr[WIN_LSB-1:0];

  // R8: at most one slice comparator can match
  always_comb begin
    if (!$isunknown(match))
      p_one_match_r8: assert ($onehot0(match));
  end
endmodule

// File: rtl/owd_top.sv
module owd_top #(
  parameter int ADDR_W   = 32,
  parameter int WIN_LSB  = 23,
  parameter int WIN_BITS = 5,
  parameter int GEN_LSB  = 7,
  parameter logic [3:0] REGION_TAG = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              fwd_valid,
  output logic              fwd_hit,
  output logic [4:0]        fwd_index,
  output logic [ADDR_W-1:0] fwd_addr
);
  import owd_pkg::*;

  localparam int NUM_WIN  = 1 << WIN_BITS;
  localparam int LAST_WIN = NUM_WIN - 1;
  localparam int TAG_LSB  = WIN_LSB + WIN_BITS;

  logic               glob_en;
  logic [NUM_WIN-1:0] win_en;
  owd_result_t        res;

  owd_cfg_regs #(
    .DATA_W(ADDR_W), .NUM_WIN(NUM_WIN), .GEN_LSB(GEN_LSB),
    .GEN_W(2), .GEN_CODE(2'b01)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .glob_en(glob_en), .win_en(win_en)
  );

  owd_window_match #(
    .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .WIN_BITS(WIN_BITS),
    .REGION_TAG(REGION_TAG)
  ) u_match (
    .glob_en(glob_en), .win_en(win_en), .addr(req_addr), .res(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_hit   <= 1'b0;
      fwd_index <= '0;
      fwd_addr  <= '0;
    end else begin
      fwd_valid <= req_valid;
      fwd_hit   <= req_valid && res.hit;
      fwd_index <= (req_valid && res.hit) ? res.idx : 5'd0;
      if (req_valid)
        fwd_addr <= req_addr;
    end
  end

  p_hit_valid_r8: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |-> fwd_valid);
  p_idx_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !fwd_hit |-> fwd_index == 5'd0);
  p_hit_global_r1: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |-> $past(glob_en));
  p_region_r2: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |-> fwd_addr[ADDR_W-1:TAG_LSB] == REGION_TAG);
  p_no_edge_r3: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |-> (fwd_index != 5'd0 && fwd_index != 5'(LAST_WIN)));
  p_pass_addr_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> fwd_addr == $past(req_addr));
  p_hold_addr_r5: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(fwd_addr));
endmodule

// File: tb/sim_owd_top.sv
`timescale 1ns/1ps
module sim_owd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        fwd_valid, fwd_hit;
  logic [4:0]  fwd_index;
  logic [31:0] fwd_addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_ctl = '0;
  logic [31:0] m_en = '0;
  logic [31:0] m_addr = '0;

  always #2.5 clk = ~clk;

  owd_top u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .fwd_valid(fwd_valid), .fwd_hit(fwd_hit), .fwd_index(fwd_index),
    .fwd_addr(fwd_addr)
  );

  task automatic check(input string tag, input logic v, input logic h,
                       input logic [4:0] ix, input logic [31:0] a);
    checks++;
    if (fwd_valid !== v || fwd_hit !== h || fwd_index !== ix || fwd_addr !== a) begin
      fails++;
      $display("FAIL %s: got v=%0b hit=%0b idx=%0d addr=%h, want v=%0b hit=%0b idx=%0d addr=%h",
               tag, fwd_valid, fwd_hit, fwd_index, fwd_addr, v, h, ix, a);
    end
  endtask

  // one clock: drive, predict from pre-edge model state, compare after the edge
  task automatic step(input logic we, input logic sel, input logic [31:0] wd,
                      input logic v, input logic [31:0] a, input string tag);
    logic glob, h;
    logic [4:0] ix;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    req_valid = v; req_addr = a;
    glob = (m_ctl[8:7] == 2'b01);
    ix = a[27:23];
    h = v && glob && (a[31:28] == 4'hF) && ix != 5'd0 && ix != 5'd31 && m_en[ix];
    if (v) m_addr = a;
    @(posedge clk);
    if (we) begin
      if (sel) m_en = wd; else m_ctl = wd;
    end
    #1;
    check(tag, v, h, h ? ix : 5'd0, m_addr);
  endtask

  function automatic logic [31:0] slice_addr(input int i, input logic [22:0] off);
    return 32'hF000_0000 + (i << 23) + {9'd0, off};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7", 1'b0, 1'b0, 5'd0, 32'h0);
    @(negedge clk); rst = 1'b0;
    // R7: registers cleared, nothing forwards
    step(0, 0, 0, 1, slice_addr(5, 0), "R7");
    step(1, 1, 32'hFFFF_FFFF, 0, 0, "R5");
    // R1: disabled codes
    step(1, 0, 32'h0000_0000, 1, slice_addr(5, 0), "R1");
    step(0, 0, 0, 1, slice_addr(5, 0), "R1");
    step(1, 0, 32'h0000_0100, 0, 0, "R1");
    step(0, 0, 0, 1, slice_addr(7, 0), "R1");
    step(1, 0, 32'h0000_0180, 0, 0, "R1");
    step(0, 0, 0, 1, slice_addr(7, 0), "R1");
    // R1: code 01 with other control bits set
    step(1, 0, 32'hFFFF_FEFF, 0, 0, "R1");
    // R4/R3: first and last byte of each slice, all enables set
    for (int i = 0; i < 32; i++) begin
      step(0, 0, 0, 1, slice_addr(i, 23'd0), (i == 0 || i == 31) ? "R3" : "R4");
      step(0, 0, 0, 1, slice_addr(i, 23'h7F_FFFF), (i == 0 || i == 31) ? "R3" : "R4");
    end
    // R2: outside the region
    step(0, 0, 0, 1, 32'hEF80_0000, "R2");
    step(0, 0, 0, 1, 32'h0880_0000, "R2");
    step(0, 0, 0, 1, 32'h7FFF_FFFF, "R2");
    // R5/R8: idle cycles hold the address
    step(0, 0, 0, 0, slice_addr(9, 0), "R5");
    step(0, 0, 0, 0, 32'h1234_5678, "R8");
    // R4: sparse enable pattern
    step(1, 1, 32'h5555_AAAA, 0, 0, "R4");
    for (int i = 0; i < 32; i++)
      step(0, 0, 0, 1, slice_addr(i, 23'h12_3456), "R4");
    // R6: write in same cycle as request uses old value
    step(1, 1, 32'h0000_0000, 1, slice_addr(2, 0), "R6");
    step(0, 0, 0, 1, slice_addr(2, 0), "R6");
    step(1, 1, 32'h0000_0008, 1, slice_addr(3, 0), "R6");
    step(0, 0, 0, 1, slice_addr(3, 0), "R6");
    step(1, 0, 32'h0000_0000, 1, slice_addr(3, 4), "R6");
    step(0, 0, 0, 1, slice_addr(3, 4), "R6");
    step(1, 0, 32'h0000_0080, 1, slice_addr(3, 8), "R6");
    step(0, 0, 0, 1, slice_addr(3, 8), "R6");
    // R3: only edge bits set
    step(1, 1, 32'h8000_0001, 0, 0, "R3");
    step(0, 0, 0, 1, slice_addr(0, 23'h10), "R3");
    step(0, 0, 0, 1, slice_addr(31, 23'h10), "R3");
    // R7: reset in mid-run clears registers again
    @(negedge clk); rst = 1'b1; req_valid = 0; cfg_we = 0;
    @(posedge clk); #1;
    m_ctl = '0; m_en = '0; m_addr = '0;
    check("R7", 1'b0, 1'b0, 5'd0, 32'h0);
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, 1, slice_addr(3, 0), "R7");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, want completion within 5000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule